// File: doc/BRIEF.md
# Thermal Overheat Monitor with Hysteresis

The block receives signed temperature codes from a sensor front end, one per strobe, and keeps the most recent code in a status register. The status register also carries a flag that shows whether any result has arrived yet. Each code is compared with a programmable threshold. A two-bit band select sets the hysteresis. The comparison drives a two-state alarm, NORMAL and HOT, so that a code hovering near the threshold does not make the alarm chatter. Each entry into HOT sets an overheat cause bit. That bit reaches the single interrupt output only when three things are set: a per-source mask bit, a summary enable and a control-register interrupt enable.

Software reaches the block through a 32-bit word register bus. Reads are strobed and return data one cycle later. Reading the cause register clears it. The codes are linear in temperature and a larger code means a hotter die. The step is about 0.423 degrees per code, so the four hysteresis bands come out as 4, 9, 18 and 36 codes. The bands are derived at elaboration from parameters given in millidegrees.

Top module: `thermwatch_top`

## Requirements
- R1: After reset the status word (byte address 0x04) reads 0. Each strobed sample is stored as a 10-bit two's complement code in status bits [9:0]. Status bit 16 becomes 1 with the first sample and stays 1.
- R2: The control word (address 0x00) stores the threshold in bits [12:3], the hysteresis select in bits [20:19] and the interrupt enable in bit 25. The mask word (0x0C) stores only bit 22. The summary word (0x10) stores only bit 1. All other bits of these words read 0, and every register reads 0 after reset.
- R3: With band size D = 4, 9, 18 or 36 for select 0 to 3, the high watermark is the threshold plus D. A sample at or above the high watermark while NORMAL moves the alarm to HOT and sets cause bit 22 (address 0x08). A sample below the high watermark leaves the cause bit clear.
- R4: While HOT, the alarm returns to NORMAL only on a sample at or below the low watermark, which is the threshold minus D. Samples above the low watermark keep it HOT, and no further cause is set until the alarm has returned to NORMAL.
- R5: Threshold, samples and watermarks are all compared as signed values, including negative thresholds and negative codes.
- R6: Watermark arithmetic saturates at +511 and -512 and does not wrap. With threshold 510 a sample of 511 still raises the alarm, and with threshold -510 a sample of -512 still clears it.
- R7: A read of the cause word returns the current cause bits and then clears them. Without a read, the cause bit stays set.
- R8: If an overheat event and a cause read happen in the same cycle, that read returns the value held before the event, and the cause bit remains set for the next read.
- R9: The interrupt output is high exactly when the cause bit, mask bit 22, summary bit 1 and control bit 25 are all set. Clearing any one of them drops it.
- R10: Writes to the status and cause addresses have no effect on what those registers read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid next cycle |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| samp_vld | input | 1 | Sample strobe |
| samp_code | input | 10 | Signed temperature code |
| ovh_irq | output | 1 | Overheat interrupt |

## Verification
Every code from -512 to +511 is driven against a zero threshold at each of the four band settings. Each code is checked twice, once as a rising sample from a cold state and once as a falling sample from HOT. This places both watermarks exactly and shows that the hysteresis gap is really kept. Windows around thresholds near both rails and at negative values separate saturation from wrap-around, and signed compares from unsigned ones. Directed patterns make an event coincide with a cause read, switch off each interrupt gate in turn, and write to the read-only words. These patterns tell the read-old-value ordering and the four-way gating apart from simpler variants.

// File: rtl/thermwatch_pkg.sv
package thermwatch_pkg;

   // Word indices of the register map (byte address >> 2)
   localparam int REG_CTRL  = 0;
   localparam int REG_STAT  = 1;
   localparam int REG_CAUSE = 2;
   localparam int REG_MASK  = 3;
   localparam int REG_SUMM  = 4;

   // Field positions software depends on
   localparam int CTRL_THR_LSB   = 3;
   localparam int CTRL_HYST_LSB  = 19;
   localparam int CTRL_IE_BIT    = 25;
   localparam int STAT_VALID_BIT = 16;
   localparam int CAUSE_HOT_BIT  = 22;
   localparam int SUMM_EN_BIT    = 1;
   localparam int HYST_W         = 2;

   typedef enum logic {
      ST_NORMAL = 1'b0,
      ST_HOT    = 1'b1
   } alarm_state_e;

   // Band half-width in codes, rounded to nearest, for band step 'step'
   function automatic int band_codes(input int step, input int base_mc, input int mc_per_code);
      return ((base_mc << step) + mc_per_code / 2) / mc_per_code;
   endfunction

endpackage

// File: rtl/thermwatch_watermark.sv
module thermwatch_watermark
   import thermwatch_pkg::*;
#(
   parameter int CODE_W      = 10,
   parameter int BASE_MC     = 1900,
   parameter int MC_PER_CODE = 423
) (
   input  logic signed [CODE_W-1:0] thr_i,
   input  logic        [HYST_W-1:0] hyst_i,
   output logic signed [CODE_W-1:0] hi_o,
   output logic signed [CODE_W-1:0] lo_o
);

   localparam int LEVELS = 1 << HYST_W;
   localparam int EXT_W  = CODE_W + 8;
   localparam int MAX_I  = (1 << (CODE_W - 1)) - 1;
   localparam int MIN_I  = -(1 << (CODE_W - 1));
   localparam logic signed [EXT_W-1:0] CODE_MAX = EXT_W'(MAX_I);
   localparam logic signed [EXT_W-1:0] CODE_MIN = EXT_W'(MIN_I);

   if (band_codes(LEVELS - 1, BASE_MC, MC_PER_CODE) >= (1 << (EXT_W - 2))) begin : g_band_too_wide
      $error("thermwatch_watermark: widest band does not fit the extended width");
   end
   if (MC_PER_CODE < 1) begin : g_bad_step
      $error("thermwatch_watermark: MC_PER_CODE must be positive");
   end

   logic signed [EXT_W-1:0] band_tab [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_band
      localparam int BAND = band_codes(g, BASE_MC, MC_PER_CODE);
      assign band_tab[g] = EXT_W'(BAND);
   end

   logic signed [EXT_W-1:0] thr_x;
   logic signed [EXT_W-1:0] delta;
   logic signed [EXT_W-1:0] up_x;
   logic signed [EXT_W-1:0] dn_x;

   assign thr_x = {{(EXT_W - CODE_W){thr_i[CODE_W-1]}}, thr_i};
   assign delta = band_tab[hyst_i];
   assign up_x  = thr_x + delta;
   assign dn_x  = thr_x - delta;

   always_comb begin
      if (up_x > CODE_MAX) begin
         hi_o = CODE_MAX[CODE_W-1:0];
      end else begin
         hi_o = up_x[CODE_W-1:0];
      end
      if (dn_x < CODE_MIN) begin
         lo_o = CODE_MIN[CODE_W-1:0];
      end else begin
         lo_o = dn_x[CODE_W-1:0];
      end
   end

endmodule

// File: rtl/thermwatch_alarm.sv
module thermwatch_alarm
   import thermwatch_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     samp_vld_i,
   input  logic signed [CODE_W-1:0] samp_code_i,
   input  logic signed [CODE_W-1:0] hi_i,
   input  logic signed [CODE_W-1:0] lo_i,
   output logic                     hot_o,
   output logic                     event_o
);

   alarm_state_e state_q;
   alarm_state_e state_d;

   always_comb begin
      state_d = state_q;
      event_o = 1'b0;
      if (samp_vld_i) begin
         unique case (state_q)
            ST_NORMAL: begin
               if (samp_code_i >= hi_i) begin
                  state_d = ST_HOT;
                  event_o = 1'b1;
               end
            end
            ST_HOT: begin
               if (samp_code_i <= lo_i) begin
                  state_d = ST_NORMAL;
               end
            end
            default: state_d = ST_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_NORMAL;
      end else begin
         state_q <= state_d;
      end
   end

   assign hot_o = (state_q == ST_HOT);

endmodule

// File: rtl/thermwatch_regs.sv
module thermwatch_regs
   import thermwatch_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr_i,
   input  logic                     reg_rd_i,
   input  logic [ADDR_W-1:0]        reg_addr_i,
   input  logic [DATA_W-1:0]        reg_wdata_i,
   output logic [DATA_W-1:0]        reg_rdata_o,
   input  logic                     samp_vld_i,
   input  logic signed [CODE_W-1:0] samp_code_i,
   input  logic                     hot_event_i,
   output logic signed [CODE_W-1:0] thr_o,
   output logic [HYST_W-1:0]        hyst_o,
   output logic signed [CODE_W-1:0] stat_code_o,
   output logic                     stat_valid_o,
   output logic                     cause_o,
   output logic                     cause_rd_o,
   output logic                     irq_o
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              sel_ctrl, sel_stat, sel_cause, sel_mask, sel_summ;

   assign word      = reg_addr_i[ADDR_W-1:2];
   assign sel_ctrl  = (word == WORD_W'(REG_CTRL));
   assign sel_stat  = (word == WORD_W'(REG_STAT));
   assign sel_cause = (word == WORD_W'(REG_CAUSE));
   assign sel_mask  = (word == WORD_W'(REG_MASK));
   assign sel_summ  = (word == WORD_W'(REG_SUMM));

   logic signed [CODE_W-1:0] thr_q;
   logic [HYST_W-1:0]        hyst_q;
   logic                     ie_q;
   logic                     mask_q;
   logic                     summ_q;
   logic signed [CODE_W-1:0] code_q;
   logic                     valid_q;
   logic                     cause_q;
   logic [DATA_W-1:0]        rd_mux;
   logic [DATA_W-1:0]        rdata_q;

   // Control, mask and summary enable: software writable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= '0;
         hyst_q <= '0;
         ie_q   <= 1'b0;
         mask_q <= 1'b0;
         summ_q <= 1'b0;
      end else if (reg_wr_i) begin
         if (sel_ctrl) begin
            thr_q  <= $signed(reg_wdata_i[CTRL_THR_LSB +: CODE_W]);
            hyst_q <= reg_wdata_i[CTRL_HYST_LSB +: HYST_W];
            ie_q   <= reg_wdata_i[CTRL_IE_BIT];
         end
         if (sel_mask) begin
            mask_q <= reg_wdata_i[CAUSE_HOT_BIT];
         end
         if (sel_summ) begin
            summ_q <= reg_wdata_i[SUMM_EN_BIT];
         end
      end
   end

   // Status: latest sample and sticky valid flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         valid_q <= 1'b0;
      end else if (samp_vld_i) begin
         code_q  <= samp_code_i;
         valid_q <= 1'b1;
      end
   end

   // Cause: a new event wins over a clearing read in the same cycle
   assign cause_rd_o = reg_rd_i && sel_cause;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= 1'b0;
      end else if (hot_event_i) begin
         cause_q <= 1'b1;
      end else if (cause_rd_o) begin
         cause_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sel_ctrl) begin
         rd_mux[CTRL_THR_LSB +: CODE_W]  = thr_q;
         rd_mux[CTRL_HYST_LSB +: HYST_W] = hyst_q;
         rd_mux[CTRL_IE_BIT]             = ie_q;
      end
      if (sel_stat) begin
         rd_mux[CODE_W-1:0]     = code_q;
         rd_mux[STAT_VALID_BIT] = valid_q;
      end
      if (sel_cause) begin
         rd_mux[CAUSE_HOT_BIT] = cause_q;
      end
      if (sel_mask) begin
         rd_mux[CAUSE_HOT_BIT] = mask_q;
      end
      if (sel_summ) begin
         rd_mux[SUMM_EN_BIT] = summ_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (reg_rd_i) begin
         rdata_q <= rd_mux;
      end
   end

   logic unused_bus;
   assign unused_bus = ^{reg_addr_i[1:0], reg_wdata_i};

   assign reg_rdata_o  = rdata_q;
   assign thr_o        = thr_q;
   assign hyst_o       = hyst_q;
   assign stat_code_o  = code_q;
   assign stat_valid_o = valid_q;
   assign cause_o      = cause_q;
   assign irq_o        = cause_q & mask_q & summ_q & ie_q;

endmodule

// File: rtl/thermwatch_top.sv
module thermwatch_top
   import thermwatch_pkg::*;
#(
   parameter int CODE_W      = 10,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int BASE_MC     = 1900,
   parameter int MC_PER_CODE = 423
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   input  logic                     samp_vld,
   input  logic signed [CODE_W-1:0] samp_code,
   output logic                     ovh_irq
);

   if (CODE_W < 4 || CODE_W > 16) begin : g_bad_code_w
      $error("thermwatch_top: CODE_W must lie in 4..16");
   end
   if (DATA_W < CTRL_IE_BIT + 1) begin : g_bad_data_w
      $error("thermwatch_top: DATA_W too narrow for the field layout");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("thermwatch_top: ADDR_W must cover five register words");
   end

   logic signed [CODE_W-1:0] thr_val;
   logic [HYST_W-1:0]        hyst_sel;
   logic signed [CODE_W-1:0] wm_hi;
   logic signed [CODE_W-1:0] wm_lo;
   logic                     alarm_hot;
   logic                     hot_event;
   logic signed [CODE_W-1:0] stat_code;
   logic                     stat_valid;
   logic                     cause_bit;
   logic                     cause_rd;

   thermwatch_watermark #(
      .CODE_W      (CODE_W),
      .BASE_MC     (BASE_MC),
      .MC_PER_CODE (MC_PER_CODE)
   ) u_wm (
      .thr_i  (thr_val),
      .hyst_i (hyst_sel),
      .hi_o   (wm_hi),
      .lo_o   (wm_lo)
   );

   thermwatch_alarm #(
      .CODE_W (CODE_W)
   ) u_alarm (
      .clk         (clk),
      .rst_n       (rst_n),
      .samp_vld_i  (samp_vld),
      .samp_code_i (samp_code),
      .hi_i        (wm_hi),
      .lo_i        (wm_lo),
      .hot_o       (alarm_hot),
      .event_o     (hot_event)
   );

   thermwatch_regs #(
      .CODE_W (CODE_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr_i     (reg_wr),
      .reg_rd_i     (reg_rd),
      .reg_addr_i   (reg_addr),
      .reg_wdata_i  (reg_wdata),
      .reg_rdata_o  (reg_rdata),
      .samp_vld_i   (samp_vld),
      .samp_code_i  (samp_code),
      .hot_event_i  (hot_event),
      .thr_o        (thr_val),
      .hyst_o       (hyst_sel),
      .stat_code_o  (stat_code),
      .stat_valid_o (stat_valid),
      .cause_o      (cause_bit),
      .cause_rd_o   (cause_rd),
      .irq_o        (ovh_irq)
   );

endmodule

// File: rtl/thermwatch_chk.sv
module thermwatch_chk #(
   parameter int CODE_W = 10
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     samp_vld,
   input logic signed [CODE_W-1:0] samp_code,
   input logic                     hot,
   input logic                     cause,
   input logic                     cause_rd,
   input logic                     stat_valid,
   input logic signed [CODE_W-1:0] stat_code,
   input logic signed [CODE_W-1:0] thr,
   input logic signed [CODE_W-1:0] hi,
   input logic signed [CODE_W-1:0] lo,
   input logic                     irq
);

   AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      samp_vld |=> (stat_valid && stat_code == $past(samp_code))); // R1

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |=> stat_valid); // R1

   AST_HOT_ENTRY_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hot) |-> cause); // R3

   AST_HOT_EXIT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hot) |-> ($past(samp_vld) && $past(samp_code) <= $past(lo))); // R4

   AST_WM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (lo <= thr) && (thr <= hi)); // R6

   AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cause && !cause_rd) |=> cause); // R7

   AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cause); // R9

endmodule

bind thermwatch_top thermwatch_chk #(.CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .samp_vld   (samp_vld),
   .samp_code  (samp_code),
   .hot        (alarm_hot),
   .cause      (cause_bit),
   .cause_rd   (cause_rd),
   .stat_valid (stat_valid),
   .stat_code  (stat_code),
   .thr        (thr_val),
   .hi         (wm_hi),
   .lo         (wm_lo),
   .irq        (ovh_irq)
);

// File: tb/tb_thermwatch_top.sv
`timescale 1ns/1ps
module tb_thermwatch_top;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [4:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              samp_vld = 1'b0;
   logic signed [9:0] samp_code = '0;
   logic              ovh_irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   localparam int A_CTRL = 'h00, A_STAT = 'h04, A_CAUSE = 'h08, A_MASK = 'h0C, A_SUMM = 'h10;

   always #2 clk = ~clk;

   thermwatch_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .samp_vld  (samp_vld),
      .samp_code (samp_code),
      .ovh_irq   (ovh_irq)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 5'(a);
      @(posedge clk); #1;
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic samp(input int c);
      @(negedge clk);
      samp_vld = 1'b1; samp_code = 10'(c);
      @(posedge clk); #1;
      samp_vld = 1'b0;
   endtask

   function automatic int band(input int h);
      case (h)
         0: return 4;
         1: return 9;
         2: return 18;
         default: return 36;
      endcase
   endfunction

   function automatic int hi_wm(input int t, input int h);
      return (t + band(h) > 511) ? 511 : t + band(h);
   endfunction

   function automatic int lo_wm(input int t, input int h);
      return (t - band(h) < -512) ? -512 : t - band(h);
   endfunction

   function automatic logic [31:0] ctrl_word(input int t, input int h, input int ie);
      return (32'(t & 1023) << 3) | (32'(h) << 19) | (32'(ie) << 25);
   endfunction

   // Rising check from NORMAL, then falling check from HOT, for code c
   task automatic probe(input int t, input int h, input int c, input string tag_up, input string tag_dn);
      logic [31:0] d;
      samp(-512);
      samp(c);
      rd(A_CAUSE, d);
      chk($sformatf("%s rise thr=%0d h=%0d c=%0d", tag_up, t, h, c), d[22], (c >= hi_wm(t, h)) ? 1 : 0);
      samp(511);
      rd(A_CAUSE, d);
      samp(c);
      samp(511);
      rd(A_CAUSE, d);
      chk($sformatf("%s fall thr=%0d h=%0d c=%0d", tag_dn, t, h, c), d[22], (c <= lo_wm(t, h)) ? 1 : 0);
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int thr_list[5] = '{510, -510, -100, 300, -1};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // Reset state (R1, R2)
      rd(A_STAT, d);  chk("R1 status after reset", d, 0);
      rd(A_CTRL, d);  chk("R2 ctrl after reset", d, 0);
      rd(A_CAUSE, d); chk("R2 cause after reset", d, 0);
      rd(A_MASK, d);  chk("R2 mask after reset", d, 0);
      rd(A_SUMM, d);  chk("R2 summary after reset", d, 0);
      chk("R9 irq after reset", ovh_irq, 0);

      // Status capture (R1)
      samp(37);
      rd(A_STAT, d); chk("R1 status positive", d, 32'h0001_0025);
      samp(-5);
      rd(A_STAT, d); chk("R1 status negative", d, 32'h0001_03FB);

      // Field readback (R2)
      wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R2 ctrl fields", d, 32'h0218_1FF8);
      wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, d); chk("R2 mask field", d, 32'h0040_0000);
      wr(A_SUMM, 32'hFFFF_FFFF); rd(A_SUMM, d); chk("R2 summary field", d, 32'h0000_0002);
      wr(A_MASK, 0); wr(A_SUMM, 0);

      // Read-only words ignore writes (R10)
      wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, d); chk("R10 status unwritable", d, 32'h0001_03FB);
      wr(A_CTRL, ctrl_word(0, 0, 0));
      samp(-512);
      rd(A_CAUSE, d);
      wr(A_CAUSE, 32'hFFFF_FFFF); rd(A_CAUSE, d); chk("R10 cause unwritable", d, 0);

      // Full sweep at threshold 0 for every band (R3, R4)
      for (int h = 0; h < 4; h++) begin
         wr(A_CTRL, ctrl_word(0, h, 0));
         for (int c = -512; c <= 511; c++) probe(0, h, c, "R3", "R4");
      end

      // Windows around rail and negative thresholds (R5, R6)
      foreach (thr_list[i]) begin
         for (int h = 0; h < 4; h++) begin
            wr(A_CTRL, ctrl_word(thr_list[i], h, 0));
            for (int c = thr_list[i] - 40; c <= thr_list[i] + 40; c++) begin
               if (c >= -512 && c <= 511) begin
                  if (thr_list[i] == 510 || thr_list[i] == -510) probe(thr_list[i], h, c, "R6", "R6");
                  else probe(thr_list[i], h, c, "R5", "R5");
               end
            end
         end
      end

      // Clear on read (R7)
      wr(A_CTRL, ctrl_word(0, 0, 0));
      samp(-512); rd(A_CAUSE, d);
      samp(100);
      repeat (3) @(posedge clk);
      rd(A_CAUSE, d); chk("R7 cause held until read", d, 32'h0040_0000);
      rd(A_CAUSE, d); chk("R7 cause cleared by read", d, 0);

      // Event coinciding with a cause read (R8)
      samp(-512);
      @(negedge clk);
      samp_vld = 1'b1; samp_code = 10'sd100;
      reg_rd = 1'b1; reg_addr = 5'(A_CAUSE);
      @(posedge clk); #1;
      samp_vld = 1'b0; reg_rd = 1'b0;
      chk("R8 colliding read returns old", reg_rdata, 0);
      rd(A_CAUSE, d); chk("R8 cause kept for next read", d, 32'h0040_0000);
      rd(A_CAUSE, d); chk("R8 cleared afterwards", d, 0);

      // Interrupt gating (R9)
      wr(A_CTRL, ctrl_word(0, 0, 1));
      wr(A_MASK, 32'h0040_0000);
      wr(A_SUMM, 32'h0000_0002);
      chk("R9 no irq without cause", ovh_irq, 0);
      samp(-512); samp(100);
      chk("R9 irq all gates open", ovh_irq, 1);
      wr(A_MASK, 0);                chk("R9 mask gate", ovh_irq, 0);
      wr(A_MASK, 32'h0040_0000);    chk("R9 mask restored", ovh_irq, 1);
      wr(A_SUMM, 0);                chk("R9 summary gate", ovh_irq, 0);
      wr(A_SUMM, 32'h0000_0002);    chk("R9 summary restored", ovh_irq, 1);
      wr(A_CTRL, ctrl_word(0, 0, 0)); chk("R9 enable gate", ovh_irq, 0);
      wr(A_CTRL, ctrl_word(0, 0, 1)); chk("R9 enable restored", ovh_irq, 1);
      rd(A_CAUSE, d);               chk("R9 irq drops on cause read", ovh_irq, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule